// File: doc/BRIEF.md
# Card Byte Stream to Halfword FIFO Transfer Engine

This block carries block-structured data between a byte-wide card data port and a 16-bit circular FIFO. On a read, bytes arriving from the card are paired into FIFO words. The earlier byte of each pair goes into the low half of the word. On a write, each word at the head of the FIFO is split into two bytes toward the card, low half first. Transfers are counted in blocks of a programmed byte length. When a block has an odd length, its last byte stands alone in a word.

Software-side logic fills or drains the FIFO through a host push/pop port. It then starts a transfer with a direction, a block length in bytes, a block count and an almost-full watermark. The engine throttles itself on FIFO occupancy. It drops its busy flag and pulses a done signal after the final byte of the final block.

Top module: `card_xfer_engine`

## Requirements
- R1: After reset the engine is idle (`busy` low), `fifo_level` is 0, `card_rx_ready` is low and `card_tx_valid` is low.
- R2: In read mode (`dir_rd`=1), the first byte accepted for a word lands in bits 7:0 and the second byte in bits 15:8 of the word pushed into the FIFO. Words leave the host port in arrival order.
- R3: In read mode, the last byte of a block with an odd length is pushed alone, with bits 15:8 equal to 0x00. The next block starts a fresh word.
- R4: In read mode, `card_rx_ready` is low at the start of a word (before its low byte) while `fifo_level` is greater than `af_level`. With no host draining, the transfer therefore stops with `fifo_level` equal to `af_level`+1.
- R5: In write mode (`dir_rd`=0), the engine sends bits 7:0 of the FIFO head entry, then bits 15:8. The entry is popped after the second byte.
- R6: In write mode, the last byte of an odd-length block is bits 7:0 of the head entry. That entry is then popped and its bits 15:8 are never sent.
- R7: In write mode, `card_tx_valid` stays low while the FIFO is empty. The transfer resumes once the host pushes a word.
- R8: Each byte handshake consumes one byte of the block. After `blk_len` bytes the next block begins. After `blk_num` blocks, `busy` falls and `xfer_done` is high for exactly one cycle.
- R9: FIFO indexes wrap modulo `DEPTH`, so transfers of more than `DEPTH` words keep their order.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: A `start` with `blk_len`=0 or `blk_num`=0 moves no data, leaves `busy` low and pulses `xfer_done` in the next cycle.
- R12: Host pushes are ignored while a read transfer runs or when the FIFO holds `DEPTH` words. Host pops are ignored while a write transfer runs or when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer when idle |
| dir_rd | input | 1 | 1: card to FIFO, 0: FIFO to card |
| blk_len | input | LEN_W | Bytes per block |
| blk_num | input | NBLK_W | Number of blocks |
| af_level | input | $clog2(DEPTH) | Almost-full watermark for reads |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Engine takes the offered byte |
| card_tx_valid | output | 1 | Engine offers a byte |
| card_tx_data | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card takes the offered byte |
| host_push | input | 1 | Host writes a word into the FIFO |
| host_wdata | input | 16 | Word to push |
| host_pop | input | 1 | Host removes the head word |
| host_rdata | output | 16 | Current head word |
| fifo_level | output | $clog2(DEPTH)+1 | Words held in the FIFO |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse at transfer end |

## Verification
The bench builds the engine with `DEPTH`=8 and keeps the 12-bit length and 8-bit block-count widths. The shallow FIFO brings index wraparound within reach after a few dozen bytes, and it also makes the full condition on the host port easy to hit. A watermark of 2 lets the read stall be seen at an exact occupancy of three words. Odd and even block lengths, multi-block runs and starts with zero length are each driven in both directions where they apply.

// File: rtl/card_xfer_engine.sv
module card_xfer_engine #(
  parameter int DEPTH  = 32,
  parameter int LEN_W  = 12,
  parameter int NBLK_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_rd,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [NBLK_W-1:0] blk_num,
  input  logic [PTR_W-1:0]  af_level,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_data,
  input  logic              card_tx_ready,
  input  logic              host_push,
  input  logic [15:0]       host_wdata,
  input  logic              host_pop,
  output logic [15:0]       host_rdata,
  output logic [PTR_W:0]    fifo_level,
  output logic              busy,
  output logic              xfer_done
);

  logic [15:0]       mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [PTR_W:0]    level;
  logic              busy_q, dir_q, half_q, done_q;
  logic [7:0]        lo_q;
  logic [LEN_W-1:0]  len_q, len_rl;
  logic [NBLK_W-1:0] blk_q;

  wire rd_mode  = busy_q & dir_q;
  wire wr_mode  = busy_q & ~dir_q;
  wire rx_fire  = card_rx_valid & card_rx_ready;
  wire tx_fire  = card_tx_valid & card_tx_ready;
  wire byte_go  = rx_fire | tx_fire;
  wire blk_last = (len_q == LEN_W'(1));
  wire empty    = (level == '0);
  wire full     = (level == (PTR_W+1)'(DEPTH));

  wire eng_push = rx_fire & (half_q | blk_last);
  wire eng_pop  = tx_fire & (half_q | blk_last);
  wire h_push   = host_push & ~rd_mode & ~full;
  wire h_pop    = host_pop & ~wr_mode & ~empty;
  wire do_push  = eng_push | h_push;
  wire do_pop   = eng_pop | h_pop;

  wire [15:0] push_word = eng_push ? (half_q ? {card_rx_data, lo_q} : {8'h00, card_rx_data})
                                   : host_wdata;

  assign card_rx_ready = rd_mode & (half_q | (level <= {1'b0, af_level}));
  assign card_tx_valid = wr_mode & ~empty;
  assign host_rdata    = mem[rd_ptr];
  assign card_tx_data  = half_q ? host_rdata[15:8] : host_rdata[7:0];
  assign fifo_level    = level;
  assign busy          = busy_q;
  assign xfer_done     = done_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      lo_q   <= '0;
      len_q  <= '0;
      len_rl <= '0;
      blk_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        if (blk_len == '0 || blk_num == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          dir_q  <= dir_rd;
          half_q <= 1'b0;
          len_q  <= blk_len;
          len_rl <= blk_len;
          blk_q  <= blk_num;
        end
      end else if (byte_go) begin
        if (rx_fire && !half_q) lo_q <= card_rx_data;
        if (blk_last) begin
          half_q <= 1'b0;
          len_q  <= len_rl;
          blk_q  <= blk_q - 1'b1;
          if (blk_q == NBLK_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          half_q <= ~half_q;
          len_q  <= len_q - 1'b1;
        end
      end
    end
  end

endmodule

module card_xfer_engine_chk #(
  parameter int DEPTH  = 32,
  parameter int LEN_W  = 12,
  parameter int NBLK_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] blk_len,
  input logic [PTR_W-1:0] af_level,
  input logic             card_rx_valid,
  input logic             card_rx_ready,
  input logic             card_tx_valid,
  input logic             card_tx_ready,
  input logic [PTR_W:0]   fifo_level,
  input logic             busy,
  input logic             xfer_done,
  input logic             half_q,
  input logic [LEN_W-1:0] len_q
);
  wire byte_go = (card_rx_valid & card_rx_ready) | (card_tx_valid & card_tx_ready);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= (PTR_W+1)'(DEPTH)); // R12
  AST_RX_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_q && fifo_level > {1'b0, af_level}) |-> !card_rx_ready); // R4
  AST_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0) |-> !card_tx_valid); // R7
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_rx_ready && card_tx_valid)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy); // R8
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_go && len_q > LEN_W'(1)) |=> (len_q == $past(len_q) - 1'b1)); // R8
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && blk_len == '0) |=> (xfer_done && !busy)); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !byte_go) |=> (len_q == $past(len_q))); // R10
endmodule

bind card_xfer_engine card_xfer_engine_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .NBLK_W(NBLK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len), .af_level(af_level),
  .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
  .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
  .fifo_level(fifo_level), .busy(busy), .xfer_done(xfer_done),
  .half_q(half_q), .len_q(len_q)
);

// File: tb/card_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module card_xfer_engine_tb_top;
  localparam int DEPTH = 8;
  localparam int LEN_W = 12;
  localparam int NBLK_W = 8;
  localparam int PTR_W = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic start = 0, dir_rd = 0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [NBLK_W-1:0] blk_num = '0;
  logic [PTR_W-1:0] af_level = '0;
  logic card_rx_valid = 0; logic [7:0] card_rx_data = '0;
  logic card_rx_ready, card_tx_valid; logic [7:0] card_tx_data;
  logic card_tx_ready = 0;
  logic host_push = 0; logic [15:0] host_wdata = '0;
  logic mon_pop = 0, force_pop = 0;
  logic [15:0] host_rdata; logic [PTR_W:0] fifo_level;
  logic busy, xfer_done;
  wire host_pop = mon_pop | force_pop;

  card_xfer_engine #(.DEPTH(DEPTH), .LEN_W(LEN_W), .NBLK_W(NBLK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd), .blk_len(blk_len),
    .blk_num(blk_num), .af_level(af_level), .card_rx_valid(card_rx_valid),
    .card_rx_data(card_rx_data), .card_rx_ready(card_rx_ready),
    .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data),
    .card_tx_ready(card_tx_ready), .host_push(host_push), .host_wdata(host_wdata),
    .host_pop(host_pop), .host_rdata(host_rdata), .fifo_level(fifo_level),
    .busy(busy), .xfer_done(xfer_done));

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, done_cnt = 0;
  bit rx_mon_en = 0, tx_mon_en = 0;
  logic [15:0] exp_words[$];
  logic [7:0]  exp_bytes[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitors: host side words and card side bytes
  always @(negedge clk) begin
    if (xfer_done) done_cnt++;
    if (rx_mon_en && fifo_level != 0) begin
      if (exp_words.size() == 0) chk(0, "R2 unexpected word", {16'h0, host_rdata}, 32'h0);
      else begin
        logic [15:0] w;
        w = exp_words.pop_front();
        chk(host_rdata == w, "R2/R3/R9 word", {16'h0, host_rdata}, {16'h0, w});
      end
      mon_pop = 1;
    end else mon_pop = 0;
    if (tx_mon_en && card_tx_valid) begin
      if (exp_bytes.size() == 0) chk(0, "R5 unexpected byte", {24'h0, card_tx_data}, 32'h0);
      else begin
        logic [7:0] b;
        b = exp_bytes.pop_front();
        chk(card_tx_data == b, "R5/R6 byte", {24'h0, card_tx_data}, {24'h0, b});
      end
      card_tx_ready = 1;
    end else card_tx_ready = 0;
  end

  task automatic final_report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    final_report();
  end

  task automatic do_start(input bit rd, input int len, input int nb, input int af);
    @(negedge clk);
    start = 1; dir_rd = rd; blk_len = LEN_W'(len); blk_num = NBLK_W'(nb); af_level = PTR_W'(af);
    @(negedge clk);
    start = 0;
  endtask

  function automatic logic [7:0] bval(input int seed, input int i);
    return 8'((seed + i * 37) & 8'hff);
  endfunction

  task automatic exp_read(input int len, input int nb, input int seed);
    int k = 0;
    for (int b = 0; b < nb; b++)
      for (int j = 0; j < len; j += 2) begin
        logic [7:0] lo, hi;
        lo = bval(seed, k);
        hi = (j + 1 < len) ? bval(seed, k + 1) : 8'h00;
        k += (j + 1 < len) ? 2 : 1;
        exp_words.push_back({hi, lo});
      end
  endtask

  task automatic feed(input int total, input int seed);
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      card_rx_valid = 1; card_rx_data = bval(seed, i);
      #1;
      while (!card_rx_ready) @(negedge clk);
    end
    @(negedge clk);
    card_rx_valid = 0;
  endtask

  task automatic hpush(input logic [15:0] w);
    @(negedge clk);
    while (fifo_level == DEPTH && busy) @(negedge clk);
    host_push = 1; host_wdata = w;
    @(negedge clk);
    host_push = 0;
  endtask

  task automatic wait_done(input int target, input string req);
    while (done_cnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == target, req, done_cnt, target);
    chk(busy == 0, req, busy, 0);
  endtask

  task automatic write_run(input int len, input int nb, input int seed);
    int k = 0, nw = 0;
    for (int b = 0; b < nb; b++)
      for (int j = 0; j < len; j += 2) begin
        logic [15:0] w;
        w = {bval(seed, k + 1), bval(seed, k)};
        k += 2; nw++;
        exp_bytes.push_back(w[7:0]);
        if (j + 1 < len) exp_bytes.push_back(w[15:8]);
      end
    tx_mon_en = 1;
    do_start(0, len, nb, 0);
    k = 0;
    for (int i = 0; i < nw; i++) begin
      hpush({bval(seed, k + 1), bval(seed, k)});
      k += 2;
    end
  endtask

  initial begin
    int tgt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(fifo_level == 0, "R1 level", fifo_level, 0);
    chk(card_rx_ready == 0, "R1 rx_ready", card_rx_ready, 0);
    chk(card_tx_valid == 0, "R1 tx_valid", card_tx_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && card_rx_ready == 0, "R1 after release", busy, 0);

    // R2 R8: two even blocks
    rx_mon_en = 1;
    exp_read(4, 2, 1);
    do_start(1, 4, 2, 7);
    feed(8, 1);
    tgt = 1; wait_done(tgt, "R8 done once");
    chk(exp_words.size() == 0, "R2 all words", exp_words.size(), 0);

    // R3: odd blocks, fresh word per block
    exp_read(3, 2, 50);
    do_start(1, 3, 2, 7);
    feed(6, 50);
    tgt++; wait_done(tgt, "R3 done");
    chk(exp_words.size() == 0, "R3 all words", exp_words.size(), 0);

    // R4: watermark stall without draining
    rx_mon_en = 0;
    exp_read(10, 1, 90);
    do_start(1, 10, 1, 2);
    fork feed(10, 90); join_none
    repeat (20) @(negedge clk);
    chk(fifo_level == 3, "R4 stall level", fifo_level, 3);
    chk(card_rx_ready == 0, "R4 rx_ready low", card_rx_ready, 0);
    chk(busy == 1, "R4 still busy", busy, 1);
    rx_mon_en = 1;
    tgt++; wait_done(tgt, "R4 resume");
    chk(exp_words.size() == 0, "R4 all words", exp_words.size(), 0);

    // R9: wrap with long read; R12 host push ignored during read
    exp_read(41, 1, 7);
    do_start(1, 41, 1, 7);
    fork feed(41, 7); join_none
    repeat (4) @(negedge clk);
    host_push = 1; host_wdata = 16'hdead;
    @(negedge clk); host_push = 0;
    tgt++; wait_done(tgt, "R9 wrap done");
    chk(exp_words.size() == 0, "R9 R12 all words", exp_words.size(), 0);
    chk(fifo_level == 0, "R12 no stray word", fifo_level, 0);

    // R10: start while busy ignored
    exp_read(4, 2, 120);
    do_start(1, 4, 2, 7);
    fork feed(8, 120); join_none
    repeat (3) @(negedge clk);
    start = 1; dir_rd = 0; blk_len = 1; blk_num = 1;
    @(negedge clk); start = 0;
    tgt++; wait_done(tgt, "R10 single done");
    chk(exp_words.size() == 0, "R10 words intact", exp_words.size(), 0);

    // R11: zero length and zero blocks
    do_start(1, 0, 3, 0);
    chk(xfer_done == 1 && busy == 0, "R11 zero len", {xfer_done, busy}, 2'b10);
    do_start(0, 5, 0, 0);
    chk(xfer_done == 1 && busy == 0, "R11 zero blocks", {xfer_done, busy}, 2'b10);
    tgt += 2; wait_done(tgt, "R11 done count");

    // R12: host push ignored when full
    rx_mon_en = 0;
    for (int i = 0; i <= DEPTH; i++) begin
      if (i < DEPTH) exp_words.push_back(16'h1000 + 16'(i));
      @(negedge clk); host_push = 1; host_wdata = 16'h1000 + 16'(i);
      @(negedge clk); host_push = 0;
    end
    chk(fifo_level == DEPTH, "R12 full cap", fifo_level, DEPTH);
    rx_mon_en = 1;
    repeat (DEPTH + 4) @(negedge clk);
    chk(exp_words.size() == 0 && fifo_level == 0, "R12 drain", fifo_level, 0);
    rx_mon_en = 0;

    // R5 R6 R12: preloaded write with odd block, host pop ignored
    hpush(16'h2211); hpush(16'h4433); hpush(16'h6655); hpush(16'h8877);
    do_start(0, 3, 2, 0);
    force_pop = 1; repeat (2) @(negedge clk); force_pop = 0;
    chk(fifo_level == 4, "R12 pop ignored in write", fifo_level, 4);
    exp_bytes.push_back(8'h11); exp_bytes.push_back(8'h22); exp_bytes.push_back(8'h33);
    exp_bytes.push_back(8'h55); exp_bytes.push_back(8'h66); exp_bytes.push_back(8'h77);
    tx_mon_en = 1;
    tgt++; wait_done(tgt, "R6 done");
    chk(exp_bytes.size() == 0, "R5 R6 all bytes", exp_bytes.size(), 0);
    chk(fifo_level == 0, "R6 odd entry popped", fifo_level, 0);

    // R7: write stalls on empty FIFO
    do_start(0, 2, 1, 0);
    repeat (5) @(negedge clk);
    chk(card_tx_valid == 0, "R7 no byte when empty", card_tx_valid, 0);
    chk(busy == 1, "R7 busy while empty", busy, 1);
    exp_bytes.push_back(8'hef); exp_bytes.push_back(8'hbe);
    hpush(16'hbeef);
    tgt++; wait_done(tgt, "R7 resume");
    chk(exp_bytes.size() == 0, "R7 bytes", exp_bytes.size(), 0);

    // R9: long write with wrap
    write_run(24, 2, 200);
    tgt++; wait_done(tgt, "R9 write wrap");
    chk(exp_bytes.size() == 0, "R9 write bytes", exp_bytes.size(), 0);
    tx_mon_en = 0;

    final_report();
  end
endmodule